// File: doc/BRIEF.md
# Key-Protected Clock and Power Control Unit

This block sits on a byte-wide register bus in a small controller system and runs from the 4.096 MHz reference clock. It provides two clock enables. The first is a core clock enable whose rate is the reference divided by a power of two, chosen by a 3-bit divide field. The second is a metering clock enable that always runs at one fifth of the reference. The block also drives two power-down outputs, one for the core and one for the metering section.

The power control register is guarded by a one-shot key. Writing the power key to the key register arms exactly one following bus write. If that write goes to the power control register, the new value is taken. Any other bus write uses up the key without effect. A second key arms a one-write unlock strobe toward an external timekeeping register group.

A PLL lock-lost indication makes the block request a system reset and set a sticky fault flag. The flag survives the system reset. It is cleared only by power-on reset or by an acknowledge write.

A divide change is held back until the running core divider reaches its terminal count, so the core enable never produces a short interval.

Control state machine:
- States: `LOCKED`, `PWR_ARMED`, `TIME_ARMED`.
- Transitions: any bus write from any state goes to `PWR_ARMED` if it writes 0xA7 to 0xC1, to `TIME_ARMED` if it writes 0xEA to 0xC1, and to `LOCKED` otherwise.
- Without a write, the state holds.
- Both resets return the machine to `LOCKED`.

Top module: `keyed_clk_ctrl`

## Requirements
- R1: After reset, the power register at 0xC5 reads 0x82, the fault register at 0xF4 reads 0x00, and both power-down outputs are low.
- R2: A write to 0xC5 changes the register only when the bus write just before it wrote 0xA7 to the key register at 0xC1; otherwise the register keeps its value.
- R3: An armed key is used up by the next bus write at any address. A key value other than 0xA7 or 0xEA leaves the block locked.
- R4: Writing 0xEA to 0xC1 raises `time_unlock`, which stays high until the next bus write and then falls (unless that write re-keys 0xEA).
- R5: With divide code CD in bits [2:0] of 0xC5, `core_ce` pulses once every 2^CD reference cycles (1 to 128).
- R6: A new CD takes effect at the next terminal count of the running divider. The interval in progress completes at the old length.
- R7: `meter_ce` pulses once every 5 reference cycles for every CD setting.
- R8: `meter_off` follows bit 6 of 0xC5 and `core_off` follows bit 4.
- R9: Bit 7 of 0xC5 always reads 1, and bits 5 and 3 always read 0. Writes to these bits are ignored.
- R10: A rising edge of `pll_lock_lost` gives a one-cycle `rst_req` and sets bit 4 of 0xF4. That bit survives `rst_n` and is cleared by `por_n` or by a write to 0xD8 with bit 7 set. A write to 0xD8 with bit 7 clear has no effect.
- R11: 0xC1 and 0xD8 read 0, bits other than bit 4 of 0xF4 read 0, and `sfr_rdata` is 0 when `sfr_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz reference clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, keeps the fault flag |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_we | input | 1 | Write strobe, one cycle per write |
| sfr_re | input | 1 | Read strobe |
| sfr_rdata | output | 8 | Read data, combinational |
| pll_lock_lost | input | 1 | PLL out of lock |
| core_ce | output | 1 | Divided core clock enable |
| meter_ce | output | 1 | Metering clock enable, reference / 5 |
| core_off | output | 1 | Core shutdown request |
| meter_off | output | 1 | Metering power-down |
| rst_req | output | 1 | One-cycle system reset request |
| time_unlock | output | 1 | Timekeeping group write unlock |

## Verification
On every cycle, the assertions check the following:
- A locked write to 0xC5 leaves the register unchanged.
- Both armed states last for only one write.
- The metering enable period is five cycles.
- The fixed bits of 0xC5 read correctly.
- A lock-loss edge gives a flag and a single-cycle reset request.

The bench scenarios cover the rest: core enable periods for random divide codes, the deferred divide change across a long interval, key cancellation by foreign writes and wrong keys, and flag persistence through a system reset followed by acknowledgement.

// File: rtl/kcc_pkg.sv
package kcc_pkg;
    localparam logic [7:0] ADDR_KEY    = 8'hC1;
    localparam logic [7:0] ADDR_PWR    = 8'hC5;
    localparam logic [7:0] ADDR_PERIPH = 8'hF4;
    localparam logic [7:0] ADDR_ADCGO  = 8'hD8;
    localparam logic [7:0] KEY_PWR     = 8'hA7;
    localparam logic [7:0] KEY_TIME    = 8'hEA;
    localparam int         FAULT_BIT   = 4;
    localparam int         ACK_BIT     = 7;
    localparam int         CD_W        = 3;
    localparam logic [CD_W-1:0] CD_RST = 3'd2;

    typedef enum logic [1:0] {
        LOCKED     = 2'd0,
        PWR_ARMED  = 2'd1,
        TIME_ARMED = 2'd2
    } key_state_e;

    typedef struct packed {
        logic            meter_off;
        logic            core_off;
        logic [CD_W-1:0] cd;
    } pwr_ctrl_t;
endpackage

// File: rtl/kcc_key_fsm.sv
module kcc_key_fsm
    import kcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic       pwr_wr_en,
    output logic       pwr_armed,
    output logic       time_unlock
);
    key_state_e state, state_n;

    function automatic key_state_e key_decode(input logic [7:0] a, input logic [7:0] d);
        if (a == ADDR_KEY && d == KEY_PWR)  return PWR_ARMED;
        if (a == ADDR_KEY && d == KEY_TIME) return TIME_ARMED;
        return LOCKED;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LOCKED;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            LOCKED:     if (we) state_n = key_decode(addr, wdata);
            PWR_ARMED:  if (we) state_n = key_decode(addr, wdata);
            TIME_ARMED: if (we) state_n = key_decode(addr, wdata);
            default:    state_n = LOCKED;
        endcase
    end

    always_comb begin
        pwr_armed   = (state == PWR_ARMED);
        time_unlock = (state == TIME_ARMED);
        pwr_wr_en   = pwr_armed && we && (addr == ADDR_PWR);
    end
endmodule

// File: rtl/kcc_core_div.sv
module kcc_core_div #(
    parameter int          CD_W   = 3,
    parameter logic [CD_W-1:0] CD_INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CD_W-1:0] cd_req,
    output logic            ce
);
    localparam int CNT_W = (2 ** CD_W) - 1;

    logic [CD_W-1:0]  cd_act;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim = (CNT_W'(1) << cd_act) - CNT_W'(1);
        ce  = (cnt == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            cd_act <= CD_INIT;
        end else if (ce) begin
            cnt    <= '0;
            cd_act <= cd_req;
        end else begin
            cnt    <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/kcc_meter_div.sv
module kcc_meter_div #(
    parameter int DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic ce
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    assign ce = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cnt <= '0;
        else if (ce) cnt <= '0;
        else         cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/kcc_fault.sv
module kcc_fault (
    input  logic clk,
    input  logic por_n,
    input  logic lock_lost,
    input  logic ack,
    output logic flag,
    output logic rst_req
);
    logic lock_q;
    logic rise;

    assign rise = lock_lost && !lock_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lock_q  <= 1'b0;
            flag    <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            lock_q  <= lock_lost;
            rst_req <= rise;
            if (rise)     flag <= 1'b1;
            else if (ack) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/keyed_clk_ctrl.sv
module keyed_clk_ctrl
    import kcc_pkg::*;
#(
    parameter int METER_DIV = 5
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic [7:0] sfr_addr,
    input  logic [7:0] sfr_wdata,
    input  logic       sfr_we,
    input  logic       sfr_re,
    output logic [7:0] sfr_rdata,
    input  logic       pll_lock_lost,
    output logic       core_ce,
    output logic       meter_ce,
    output logic       core_off,
    output logic       meter_off,
    output logic       rst_req,
    output logic       time_unlock
);
    logic      sys_rst_n;
    logic      pwr_wr_en;
    logic      pwr_armed;
    logic      fault_flag;
    logic      ack_wr;
    pwr_ctrl_t pc;
    logic [7:0] powcon_rd;

    assign sys_rst_n = rst_n && por_n;

    kcc_key_fsm u_key (
        .clk         (clk),
        .rst_n       (sys_rst_n),
        .we          (sfr_we),
        .addr        (sfr_addr),
        .wdata       (sfr_wdata),
        .pwr_wr_en   (pwr_wr_en),
        .pwr_armed   (pwr_armed),
        .time_unlock (time_unlock)
    );

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            pc <= '{meter_off: 1'b0, core_off: 1'b0, cd: CD_RST};
        end else if (pwr_wr_en) begin
            pc <= '{meter_off: sfr_wdata[6], core_off: sfr_wdata[4], cd: sfr_wdata[CD_W-1:0]};
        end
    end

    assign powcon_rd = {1'b1, pc.meter_off, 1'b0, pc.core_off, 1'b0, pc.cd};
    assign core_off  = pc.core_off;
    assign meter_off = pc.meter_off;

    kcc_core_div #(.CD_W(CD_W), .CD_INIT(CD_RST)) u_core_div (
        .clk    (clk),
        .rst_n  (sys_rst_n),
        .cd_req (pc.cd),
        .ce     (core_ce)
    );

    kcc_meter_div #(.DIV(METER_DIV)) u_meter_div (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .ce    (meter_ce)
    );

    assign ack_wr = sfr_we && (sfr_addr == ADDR_ADCGO) && sfr_wdata[ACK_BIT];

    kcc_fault u_fault (
        .clk       (clk),
        .por_n     (por_n),
        .lock_lost (pll_lock_lost),
        .ack       (ack_wr),
        .flag      (fault_flag),
        .rst_req   (rst_req)
    );

    always_comb begin
        sfr_rdata = 8'h00;
        if (sfr_re) begin
            unique case (sfr_addr)
                ADDR_PWR:    sfr_rdata = powcon_rd;
                ADDR_PERIPH: sfr_rdata[FAULT_BIT] = fault_flag;
                default:     sfr_rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/kcc_props.sv
module kcc_props
    import kcc_pkg::*;
#(
    parameter int METER_DIV = 5
) (
    input logic       clk,
    input logic       por_n,
    input logic       rst_n,
    input logic [7:0] sfr_addr,
    input logic [7:0] sfr_wdata,
    input logic       sfr_we,
    input logic       sfr_re,
    input logic [7:0] sfr_rdata,
    input logic       pll_lock_lost,
    input logic       pwr_armed,
    input logic [7:0] powcon_rd,
    input logic       time_unlock,
    input logic       meter_ce,
    input logic       fault_flag,
    input logic       rst_req
);
    localparam int GW = $clog2(METER_DIV + 1);
    logic [GW-1:0] gap;
    logic          srst;

    assign srst = !(rst_n && por_n);

    always_ff @(posedge clk or posedge srst) begin
        if (srst)          gap <= '0;
        else if (meter_ce) gap <= '0;
        else               gap <= gap + GW'(1);
    end

    AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (srst)
        (sfr_we && sfr_addr == ADDR_PWR && !pwr_armed) |=> $stable(powcon_rd)); // R2
    AST_PWR_KEY_ONE_SHOT: assert property (@(posedge clk) disable iff (srst)
        (pwr_armed && sfr_we && !(sfr_addr == ADDR_KEY && sfr_wdata == KEY_PWR)) |=> !pwr_armed); // R3
    AST_TIME_KEY_ONE_SHOT: assert property (@(posedge clk) disable iff (srst)
        (time_unlock && sfr_we && !(sfr_addr == ADDR_KEY && sfr_wdata == KEY_TIME)) |=> !time_unlock); // R4
    AST_METER_PERIOD: assert property (@(posedge clk) disable iff (srst)
        meter_ce |-> (gap == GW'(METER_DIV - 1))); // R7
    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (srst)
        (sfr_re && sfr_addr == ADDR_PWR) |-> (sfr_rdata[7] && !sfr_rdata[5] && !sfr_rdata[3])); // R9
    AST_FAULT_ON_LOSS: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pll_lock_lost) |=> (fault_flag && rst_req)); // R10
    AST_RST_REQ_PULSE: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req); // R10
endmodule

bind keyed_clk_ctrl kcc_props #(.METER_DIV(METER_DIV)) u_props (
    .clk           (clk),
    .por_n         (por_n),
    .rst_n         (rst_n),
    .sfr_addr      (sfr_addr),
    .sfr_wdata     (sfr_wdata),
    .sfr_we        (sfr_we),
    .sfr_re        (sfr_re),
    .sfr_rdata     (sfr_rdata),
    .pll_lock_lost (pll_lock_lost),
    .pwr_armed     (pwr_armed),
    .powcon_rd     (powcon_rd),
    .time_unlock   (time_unlock),
    .meter_ce      (meter_ce),
    .fault_flag    (fault_flag),
    .rst_req       (rst_req)
);

// File: tb/keyed_clk_ctrl_test.sv
`timescale 1ns/1ps
module keyed_clk_ctrl_test;
    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic [7:0] sfr_addr = '0, sfr_wdata = '0;
    logic       sfr_we = 1'b0, sfr_re = 1'b0;
    logic [7:0] sfr_rdata;
    logic       pll_lock_lost = 1'b0;
    logic       core_ce, meter_ce, core_off, meter_off, rst_req, time_unlock;

    int total = 0, fails = 0;
    int cyc = 0;
    int core_n = 0, core_t = 0, meter_n = 0, meter_t = 0;

    always #10 clk = ~clk;

    keyed_clk_ctrl uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we), .sfr_re(sfr_re),
        .sfr_rdata(sfr_rdata), .pll_lock_lost(pll_lock_lost),
        .core_ce(core_ce), .meter_ce(meter_ce), .core_off(core_off),
        .meter_off(meter_off), .rst_req(rst_req), .time_unlock(time_unlock)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (core_ce)  begin core_t  <= cyc; core_n  <= core_n + 1;  end
        if (meter_ce) begin meter_t <= cyc; meter_n <= meter_n + 1; end
    end

    function automatic logic [7:0] pwr_model(input logic [7:0] v);
        return 8'h80 | (v & 8'h57);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_re = 1'b1;
        #1 d = sfr_rdata;
        sfr_re = 1'b0;
    endtask

    task automatic core_gap(output int g);
        int c0, ta;
        c0 = core_n;
        while (core_n < c0 + 1) @(posedge clk);
        ta = core_t;
        while (core_n < c0 + 2) @(posedge clk);
        g = core_t - ta;
    endtask

    task automatic meter_gap(output int g);
        int c0, ta;
        c0 = meter_n;
        while (meter_n < c0 + 1) @(posedge clk);
        ta = meter_t;
        while (meter_n < c0 + 2) @(posedge clk);
        g = meter_t - ta;
    endtask

    initial begin
        #4_000_000;
        total++; fails++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] d, exp_pc, v;
        int g, t0, c0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        rd(8'hC5, d); chk(d == 8'h82, "R1 pwr reset", d, 8'h82);
        rd(8'hF4, d); chk(d == 8'h00, "R1 fault reset", d, 0);
        chk(!core_off && !meter_off, "R1 off outputs", {core_off, meter_off}, 0);
        core_gap(g); chk(g == 4, "R5 reset period", g, 4);
        exp_pc = 8'h82;

        rd(8'hC1, d); chk(d == 8'h00, "R11 key reads 0", d, 0);
        rd(8'hD8, d); chk(d == 8'h00, "R11 adcgo reads 0", d, 0);
        sfr_addr = 8'hC5; #1; chk(sfr_rdata == 8'h00, "R11 no read strobe", sfr_rdata, 0);

        wr(8'hC5, 8'h50); rd(8'hC5, d); chk(d == exp_pc, "R2 write without key", d, exp_pc);
        wr(8'hC1, 8'hA7); wr(8'h90, 8'h00); wr(8'hC5, 8'h50); rd(8'hC5, d);
        chk(d == exp_pc, "R3 foreign write cancels", d, exp_pc);
        wr(8'hC1, 8'h3C); wr(8'hC5, 8'h50); rd(8'hC5, d);
        chk(d == exp_pc, "R3 wrong key", d, exp_pc);
        wr(8'hC1, 8'hEA);
        chk(time_unlock == 1'b1, "R4 time unlock high", time_unlock, 1);
        wr(8'hC5, 8'h50); rd(8'hC5, d);
        chk(d == exp_pc, "R4 time key does not open pwr", d, exp_pc);
        chk(time_unlock == 1'b0, "R4 time unlock consumed", time_unlock, 0);
        wr(8'hC1, 8'hA7); wr(8'hC5, 8'h00); wr(8'hC5, 8'h03); rd(8'hC5, d);
        chk(d == 8'h80, "R3 key used once", d, 8'h80);
        exp_pc = 8'h80;

        wr(8'hC1, 8'hA7); wr(8'hC5, 8'hFF); rd(8'hC5, d);
        chk(d == 8'hD7, "R9 reserved bits ignored", d, 8'hD7);
        chk(core_off && meter_off, "R8 off outputs set", {core_off, meter_off}, 3);
        meter_gap(g); chk(g == 5, "R7 meter at CD 7", g, 5);
        exp_pc = 8'hD7;

        c0 = core_n;
        while (core_n < c0 + 1) @(posedge clk);
        while (core_n < c0 + 2) @(posedge clk);
        t0 = core_t;
        wr(8'hC1, 8'hA7); wr(8'hC5, 8'h00);
        exp_pc = 8'h80;
        c0 = core_n;
        while (core_n < c0 + 1) @(posedge clk);
        chk(core_t - t0 == 128, "R6 old interval completes", core_t - t0, 128);
        core_gap(g); chk(g == 1, "R6 new divide after tc", g, 1);
        meter_gap(g); chk(g == 5, "R7 meter at CD 0", g, 5);

        for (int i = 0; i < 40; i++) begin
            int mode;
            v = 8'($urandom);
            mode = int'($urandom % 4);
            wr(8'hC1, 8'hA7);
            if (mode == 1) wr(8'h90, 8'($urandom));
            if (mode == 2) wr(8'hC1, 8'h5A);
            wr(8'hC5, v);
            if (mode == 0 || mode == 3) exp_pc = pwr_model(v);
            rd(8'hC5, d); chk(d == exp_pc, "R2 random pwr write", d, exp_pc);
            chk(core_off == exp_pc[4] && meter_off == exp_pc[6], "R8 random off bits",
                {meter_off, core_off}, {exp_pc[6], exp_pc[4]});
            core_gap(g); chk(g == (1 << exp_pc[2:0]), "R5 random period", g, 1 << exp_pc[2:0]);
        end

        @(negedge clk); pll_lock_lost = 1'b1;
        @(negedge clk);
        chk(rst_req == 1'b1, "R10 reset request", rst_req, 1);
        @(negedge clk);
        chk(rst_req == 1'b0, "R10 request one cycle", rst_req, 0);
        pll_lock_lost = 1'b0;
        rd(8'hF4, d); chk(d == 8'h10, "R10 flag set", d, 8'h10);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(8'hF4, d); chk(d == 8'h10, "R10 flag survives rst_n", d, 8'h10);
        rd(8'hC5, d); chk(d == 8'h82, "R1 pwr after rst_n", d, 8'h82);
        wr(8'hD8, 8'h7F); rd(8'hF4, d); chk(d == 8'h10, "R10 ack bit clear ignored", d, 8'h10);
        wr(8'hD8, 8'h80); rd(8'hF4, d); chk(d == 8'h00, "R10 ack clears", d, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule